// File: doc/BRIEF.md
# Asynchronous Bus Master Cycle Controller

This block sits between a 16-bit processor core and an external asynchronous bus. The core issues one transfer at a time. Each request carries a 24-bit address, a 3-bit function code, a direction flag, an operand size (byte or word) and, for writes, the data. The controller steps through six bus states, S0 to S5. It drives the address, function code, size code and direction. It then asserts the address and data strobes and waits for the slave's two-bit acknowledge. In the same acknowledge the slave reports whether its port is 8 or 16 bits wide. The controller captures read data, releases the strobes and reports completion.

Byte lanes depend on operand size, address and reported port width. A 16-bit port delivers a word on the full bus and a byte on the lane its address selects. An 8-bit port always uses the upper lane. When a word is acknowledged by an 8-bit port, the controller runs a second byte cycle at the next address on its own. It then returns the two bytes joined, with the first byte in the high half. Word requests are expected at even addresses.

Top module: `asyncBusMaster`

## Requirements
- R1: While reset is held and after it, both strobes are high (negated), the data output enable is low, ready is high and done is low.
- R2: In the cycle after a request is accepted (state S0), the bus shows the request address, function code, direction (busRnW high for read) and size code (01 byte, 10 word). Both strobes stay negated in S0.
- R3: Address and data strobe go low together in S1. They stay low through S2, S3 and S4 and go high together in S5. Address, size and direction stay stable while the strobes are low.
- R4: The active-low acknowledge pair is sampled in S3. 00 means a 16-bit port, 10 means an 8-bit port, and 11 or 01 means wait. While waiting, the controller stays in S3 with the strobes low for as long as it takes.
- R5: On a 16-bit port, a word read returns busDataIn[15:0]. A byte read at an even address returns bits [15:8] and at an odd address bits [7:0], placed in doneRdata[7:0] with the upper byte zero.
- R6: On an 8-bit port, a byte read always takes busDataIn[15:8].
- R7: A word acknowledged as 8-bit triggers a second byte cycle at address+1 with size code 01. The result is the first byte in doneRdata[15:8] and the second byte in doneRdata[7:0].
- R8: A write drives a word as {high,low} on busDataOut. A byte, and the second half of a split word, is driven as the low data byte copied onto both lanes. The output enable is high from S2 to S5 of write cycles only.
- R9: done pulses for exactly one cycle, in the S5 of the last bus cycle of a transfer, and never in the S5 of the first half of a split word. ready is high only in idle, and requests presented while not ready are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Transfer request |
| reqReady | output | 1 | Controller idle, request taken this cycle |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqWord | input | 1 | 1 = word operand, 0 = byte |
| reqAddr | input | 24 | Transfer address |
| reqFc | input | 3 | Function code |
| reqWdata | input | 16 | Write data (byte in [7:0]) |
| busAddr | output | 24 | Bus address |
| busFc | output | 3 | Bus function code |
| busSiz | output | 2 | Size code, 01 byte, 10 word |
| busRnW | output | 1 | 1 = read, 0 = write |
| busAsN | output | 1 | Address strobe, active low |
| busDsN | output | 1 | Data strobe, active low |
| busDataOut | output | 16 | Write data to bus |
| busDataOe | output | 1 | Write data drive enable |
| busDataIn | input | 16 | Read data from bus |
| busDsackN | input | 2 | Acknowledge pair, active low |
| doneValid | output | 1 | Transfer complete pulse |
| doneRdata | output | 16 | Read result, valid with doneValid |

## Verification
Two things can fall in the same S5 cycle. One is the decision to finish the transfer. The other is the decision to begin the second byte cycle of a split word. The bench provokes this with word reads and writes acknowledged as 8-bit. It checks that done stays low in the first S5 and that the next S0 shows address+1 with byte size. While the strobes are low it also holds a conflicting request active, and it judges that the bus address and the completed result ignore it. A cycle-accurate bench model covers every state with variable wait lengths, and both wait encodings, and compares each cycle.

// File: rtl/busMasterPkg.sv
package busMasterPkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_S0   = 3'd1,
    ST_S1   = 3'd2,
    ST_S2   = 3'd3,
    ST_S3   = 3'd4,
    ST_S4   = 3'd5,
    ST_S5   = 3'd6
  } busState_t;

  // control -> datapath strobes
  typedef struct packed {
    logic loadReq;
    logic capturePort;
    logic latchData;
    logic startPhase2;
    logic phase2;
  } ctlStrobe_t;

  // datapath -> control status
  typedef struct packed {
    logic isWord;
    logic isWrite;
    logic port8;
  } dpStatus_t;

  localparam logic [1:0] ACK_PORT16 = 2'b00;
  localparam logic [1:0] ACK_PORT8  = 2'b10;
  localparam logic [1:0] SIZ_BYTE   = 2'b01;
  localparam logic [1:0] SIZ_WORD   = 2'b10;

endpackage

// File: rtl/busMasterCtrl.sv
module busMasterCtrl
  import busMasterPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic [1:0] dsackN,
  input  dpStatus_t  status,
  output ctlStrobe_t strobe,
  output logic       reqReady,
  output logic       asN,
  output logic       dsN,
  output logic       dataOe,
  output logic       doneValid
);

  busState_t state, stateNext;
  logic      phase2Reg;
  logic      ackSeen;
  logic      needSecond;
  logic      strobeActive;

  assign ackSeen    = (dsackN == ACK_PORT16) || (dsackN == ACK_PORT8);
  assign needSecond = status.isWord && status.port8 && !phase2Reg;

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE: if (reqValid) stateNext = ST_S0;
      ST_S0:   stateNext = ST_S1;
      ST_S1:   stateNext = ST_S2;
      ST_S2:   stateNext = ST_S3;
      ST_S3:   if (ackSeen) stateNext = ST_S4;
      ST_S4:   stateNext = ST_S5;
      ST_S5:   stateNext = needSecond ? ST_S0 : ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      phase2Reg <= 1'b0;
    end else begin
      state <= stateNext;
      if (state == ST_S5) phase2Reg <= needSecond;
    end
  end

  assign strobeActive = (state == ST_S1) || (state == ST_S2) ||
                        (state == ST_S3) || (state == ST_S4);

  always_comb begin
    strobe.loadReq     = (state == ST_IDLE) && reqValid;
    strobe.capturePort = (state == ST_S3) && ackSeen;
    strobe.latchData   = (state == ST_S4) && !status.isWrite;
    strobe.startPhase2 = (state == ST_S5) && needSecond;
    strobe.phase2      = phase2Reg;
  end

  assign reqReady  = (state == ST_IDLE);
  assign asN       = !strobeActive;
  assign dsN       = !strobeActive;
  assign dataOe    = status.isWrite &&
                     ((state == ST_S2) || (state == ST_S3) ||
                      (state == ST_S4) || (state == ST_S5));
  assign doneValid = (state == ST_S5) && !needSecond;

endmodule

// File: rtl/busMasterDatapath.sv
module busMasterDatapath
  import busMasterPkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int DATA_W = 16,
  parameter int FC_W   = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobe_t        strobe,
  input  logic              reqWrite,
  input  logic              reqWord,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [FC_W-1:0]   reqFc,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [DATA_W-1:0] busDataIn,
  input  logic [1:0]        dsackN,
  output dpStatus_t         status,
  output logic [ADDR_W-1:0] busAddr,
  output logic [FC_W-1:0]   busFc,
  output logic [1:0]        busSiz,
  output logic              busRnW,
  output logic [DATA_W-1:0] busDataOut,
  output logic [DATA_W-1:0] rdata
);

  localparam int LANE_W = DATA_W / 2;
  localparam int LANES  = DATA_W / LANE_W;

  logic [ADDR_W-1:0] addrReg;
  logic [FC_W-1:0]   fcReg;
  logic              writeReg;
  logic              wordReg;
  logic [DATA_W-1:0] wdataReg;
  logic              port8Reg;
  logic [DATA_W-1:0] rdataReg;
  logic [LANE_W-1:0] laneByte;
  logic [DATA_W-1:0] byteRepl;
  logic              fullWord;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrReg  <= '0;
      fcReg    <= '0;
      writeReg <= 1'b0;
      wordReg  <= 1'b0;
      wdataReg <= '0;
      port8Reg <= 1'b0;
    end else begin
      if (strobe.loadReq) begin
        addrReg  <= reqAddr;
        fcReg    <= reqFc;
        writeReg <= reqWrite;
        wordReg  <= reqWord;
        wdataReg <= reqWdata;
      end else if (strobe.startPhase2) begin
        addrReg <= addrReg + ADDR_W'(1);
      end
      if (strobe.capturePort) port8Reg <= (dsackN == ACK_PORT8);
    end
  end

  // byte lane: 8-bit port always upper, 16-bit port by address bit 0
  assign laneByte = (port8Reg || !addrReg[0]) ? busDataIn[DATA_W-1 -: LANE_W]
                                              : busDataIn[LANE_W-1:0];
  assign fullWord = wordReg && !strobe.phase2;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdataReg <= '0;
    end else if (strobe.latchData) begin
      if (fullWord && !port8Reg)
        rdataReg <= busDataIn;
      else if (fullWord)
        rdataReg[DATA_W-1 -: LANE_W] <= laneByte;
      else if (wordReg)
        rdataReg[LANE_W-1:0] <= laneByte;
      else
        rdataReg <= {{(DATA_W-LANE_W){1'b0}}, laneByte};
    end
  end

  // low data byte copied onto every lane for byte cycles
  for (genvar g = 0; g < LANES; g++) begin : gRepl
    assign byteRepl[g*LANE_W +: LANE_W] = wdataReg[LANE_W-1:0];
  end

  assign busDataOut = fullWord ? wdataReg : byteRepl;
  assign busSiz     = fullWord ? SIZ_WORD : SIZ_BYTE;
  assign busAddr    = addrReg;
  assign busFc      = fcReg;
  assign busRnW     = !writeReg;
  assign rdata      = rdataReg;

  always_comb begin
    status.isWord  = wordReg;
    status.isWrite = writeReg;
    status.port8   = port8Reg;
  end

endmodule

// File: rtl/asyncBusMaster.sv
module asyncBusMaster
  import busMasterPkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int DATA_W = 16,
  parameter int FC_W   = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic              reqWrite,
  input  logic              reqWord,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [FC_W-1:0]   reqFc,
  input  logic [DATA_W-1:0] reqWdata,
  output logic [ADDR_W-1:0] busAddr,
  output logic [FC_W-1:0]   busFc,
  output logic [1:0]        busSiz,
  output logic              busRnW,
  output logic              busAsN,
  output logic              busDsN,
  output logic [DATA_W-1:0] busDataOut,
  output logic              busDataOe,
  input  logic [DATA_W-1:0] busDataIn,
  input  logic [1:0]        busDsackN,
  output logic              doneValid,
  output logic [DATA_W-1:0] doneRdata
);

  ctlStrobe_t ctlStrobe;
  dpStatus_t  dpStatus;

  busMasterCtrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .reqValid  (reqValid),
    .dsackN    (busDsackN),
    .status    (dpStatus),
    .strobe    (ctlStrobe),
    .reqReady  (reqReady),
    .asN       (busAsN),
    .dsN       (busDsN),
    .dataOe    (busDataOe),
    .doneValid (doneValid)
  );

  busMasterDatapath #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .FC_W   (FC_W)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (ctlStrobe),
    .reqWrite   (reqWrite),
    .reqWord    (reqWord),
    .reqAddr    (reqAddr),
    .reqFc      (reqFc),
    .reqWdata   (reqWdata),
    .busDataIn  (busDataIn),
    .dsackN     (busDsackN),
    .status     (dpStatus),
    .busAddr    (busAddr),
    .busFc      (busFc),
    .busSiz     (busSiz),
    .busRnW     (busRnW),
    .busDataOut (busDataOut),
    .rdata      (doneRdata)
  );

endmodule

// File: rtl/busMasterChecker.sv
module busMasterChecker #(
  parameter int ADDR_W = 24,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqReady,
  input logic [ADDR_W-1:0] busAddr,
  input logic [1:0]        busSiz,
  input logic              busRnW,
  input logic              busAsN,
  input logic              busDsN,
  input logic              busDataOe,
  input logic              doneValid
);

  // R1: idle controller keeps strobes negated
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> (busAsN && busDsN && !busDataOe));

  // R3: both strobes fall together
  p_strobe_pair_r3: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busAsN) |-> $fell(busDsN));

  // R3: bus fields frozen while strobed
  p_addr_stable_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!busAsN && $past(!busAsN)) |-> ($stable(busAddr) && $stable(busSiz) && $stable(busRnW)));

  // R8: data drive only on writes
  p_oe_write_r8: assert property (@(posedge clk) disable iff (!rstN)
    busDataOe |-> !busRnW);

  // R9: done arrives as strobes release, one cycle wide
  p_done_release_r9: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |-> (busAsN && $past(!busAsN)));

  p_done_single_r9: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |=> !doneValid);

endmodule

bind asyncBusMaster busMasterChecker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/asyncBusMaster_tb.sv
`timescale 1ns/1ps
module asyncBusMaster_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic        reqWrite = 1'b0;
  logic        reqWord = 1'b0;
  logic [23:0] reqAddr = '0;
  logic [2:0]  reqFc = '0;
  logic [15:0] reqWdata = '0;
  logic [23:0] busAddr;
  logic [2:0]  busFc;
  logic [1:0]  busSiz;
  logic        busRnW;
  logic        busAsN;
  logic        busDsN;
  logic [15:0] busDataOut;
  logic        busDataOe;
  logic [15:0] busDataIn = '0;
  logic [1:0]  busDsackN = 2'b11;
  logic        doneValid;
  logic [15:0] doneRdata;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  asyncBusMaster u_dut (.*);

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  // one bus cycle from S0 to S5, current time is the negedge inside S0
  task automatic busCycle(input logic [23:0] eAddr, input logic [2:0] eFc, input logic [1:0] eSiz,
                          input bit isWr, input logic [15:0] eWdata, input int waits,
                          input logic [1:0] waitCode, input logic [1:0] ackCode,
                          input logic [15:0] slaveData, input bit expDone,
                          input logic [15:0] expRdata, input bit noise);
    // S0
    chk(busAddr == eAddr, "R2 addr", busAddr, eAddr);
    chk(busFc == eFc, "R2 fc", busFc, eFc);
    chk(busSiz == eSiz, "R2 siz", busSiz, eSiz);
    chk(busRnW == !isWr, "R2 rnw", busRnW, !isWr);
    chk(busAsN && busDsN, "R2 strobes negated in S0", {busAsN, busDsN}, 2'b11);
    chk(!doneValid, "R9 no done in S0", doneValid, 0);
    step();
    // S1
    chk(!busAsN && !busDsN, "R3 strobes asserted S1", {busAsN, busDsN}, 2'b00);
    chk(!busDataOe, "R8 oe low in S1", busDataOe, 0);
    if (noise) begin
      reqValid = 1'b1; reqAddr = 24'hBADBAD; reqWrite = ~isWr;
    end
    step();
    // S2
    chk(!busAsN && !busDsN, "R3 strobes S2", {busAsN, busDsN}, 2'b00);
    chk(busDataOe == isWr, "R8 oe S2", busDataOe, isWr);
    if (isWr) chk(busDataOut == eWdata, "R8 write data", busDataOut, eWdata);
    chk(!reqReady, "R9 not ready when busy", reqReady, 0);
    step();
    // S3 with waits
    for (int w = 0; w <= waits; w++) begin
      chk(!busAsN && !busDsN, "R4 strobes held in S3", {busAsN, busDsN}, 2'b00);
      chk(busAddr == eAddr, "R3 addr stable", busAddr, eAddr);
      if (w == waits) begin
        busDsackN = ackCode;
        busDataIn = slaveData;
      end else begin
        busDsackN = (w % 2 == 1) ? waitCode : 2'b11;
      end
      step();
    end
    // S4
    chk(!busAsN && !busDsN, "R3 strobes S4", {busAsN, busDsN}, 2'b00);
    chk(!doneValid, "R9 no done in S4", doneValid, 0);
    step();
    // S5
    busDsackN = 2'b11;
    busDataIn = 16'hDEAD;
    chk(busAsN && busDsN, "R3 strobes negated S5", {busAsN, busDsN}, 2'b11);
    chk(busDataOe == isWr, "R8 oe S5", busDataOe, isWr);
    chk(doneValid == expDone, "R9 done in S5", doneValid, expDone);
    if (expDone && !isWr) chk(doneRdata == expRdata, "R5 R6 R7 read data", doneRdata, expRdata);
    if (noise) begin
      reqValid = 1'b0; reqAddr = '0;
    end
    step();
  endtask

  task automatic xfer(input bit isWr, input bit word, input logic [23:0] addr, input logic [2:0] fc,
                      input logic [15:0] wd, input bit port8, input int waits,
                      input logic [1:0] waitCode, input logic [15:0] d1, input logic [15:0] d2,
                      input bit noise);
    logic [15:0] expR;
    logic [15:0] repl;
    logic [1:0]  ack;
    ack  = port8 ? 2'b10 : 2'b00;
    repl = {wd[7:0], wd[7:0]};
    if (word && !port8) expR = d1;
    else if (word) expR = {d1[15:8], d2[15:8]};
    else if (port8 || !addr[0]) expR = {8'h00, d1[15:8]};
    else expR = {8'h00, d1[7:0]};
    chk(reqReady, "R9 ready in idle", reqReady, 1);
    reqValid = 1'b1; reqWrite = isWr; reqWord = word; reqAddr = addr; reqFc = fc; reqWdata = wd;
    step();
    reqValid = 1'b0; reqWdata = 16'h0;
    busCycle(addr, fc, word ? 2'b10 : 2'b01, isWr, word ? wd : repl, waits, waitCode, ack, d1,
             !(word && port8), expR, noise);
    if (word && port8)
      busCycle(addr + 24'd1, fc, 2'b01, isWr, repl, waits, waitCode, ack, d2, 1'b1, expR, 1'b0); // R7
    chk(reqReady && busAsN && !doneValid, "R9 back to idle", {reqReady, busAsN, doneValid}, 3'b110);
  endtask

  initial begin
    repeat (3) step();
    // R1 during reset
    chk(busAsN && busDsN, "R1 strobes in reset", {busAsN, busDsN}, 2'b11);
    chk(!busDataOe && !doneValid && reqReady, "R1 outputs in reset", {busDataOe, doneValid, reqReady}, 3'b001);
    rstN = 1'b1;
    step(); step();
    chk(busAsN && busDsN && busRnW, "R1 after reset", {busAsN, busDsN, busRnW}, 3'b111);

    // R5 word read 16-bit port
    xfer(0, 1, 24'h001234, 3'd5, 16'h0, 0, 0, 2'b11, 16'hA1B2, 16'h0, 0);
    // R5 byte read even / odd on 16-bit port, with waits and both wait codes (R4)
    xfer(0, 0, 24'h100010, 3'd1, 16'h0, 0, 3, 2'b01, 16'h5A3C, 16'h0, 0);
    xfer(0, 0, 24'h100011, 3'd2, 16'h0, 0, 1, 2'b11, 16'h5A3C, 16'h0, 1);
    // R6 byte read 8-bit port at odd address takes upper lane
    xfer(0, 0, 24'h200003, 3'd6, 16'h0, 1, 0, 2'b11, 16'hC7E1, 16'h0, 0);
    // R7 word read split on 8-bit port, request noise during first half
    xfer(0, 1, 24'h300020, 3'd5, 16'h0, 1, 2, 2'b01, 16'h9F00, 16'h4400, 1);
    // R8 word write 16-bit port, byte write, split word write
    xfer(1, 1, 24'h400100, 3'd1, 16'hBEEF, 0, 0, 2'b11, 16'h0, 16'h0, 0);
    xfer(1, 0, 24'h400101, 3'd2, 16'h12C3, 0, 2, 2'b11, 16'h0, 16'h0, 1);
    xfer(1, 1, 24'hFFFFFE, 3'd7, 16'h6D2A, 1, 1, 2'b01, 16'h0, 16'h0, 1);
    // R4 long wait
    xfer(0, 1, 24'h000A00, 3'd5, 16'h0, 0, 60, 2'b11, 16'h0F0F, 16'h0, 0);
    // R9 back-to-back
    xfer(0, 0, 24'h000001, 3'd1, 16'h0, 1, 0, 2'b11, 16'h7700, 16'h0, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    finished = 1;
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule